// File: doc/BRIEF.md
# Low-Power State Controller

This block sits beside a small processor core and decides when the core may drop into a low-power state, which clock domains stay alive there, and when it comes back. Software sets a permission bit and a 3-bit state code, then issues a sleep strobe. If the permission bit is set and no enabled interrupt is already pending, the controller halts the core. It then gates the CPU, flash, I/O, converter and asynchronous-timer clocks according to the chosen state, and may stop the main oscillator.

While asleep, the controller watches the interrupt request lines. Each state admits only some sources as wake-up causes. On a valid wake it turns the oscillator back on if it was stopped, and waits for the start-up-done flag. It then holds the core for four more cycles and marks the first running cycle with a one-cycle service pulse. A software option turns the brown-out monitor off for the length of the sleep only. All pins are plain level control signals. There is no data stream, so there is no valid/ready handshake.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: A sleep strobe with `sleep_en` = 0 has no effect: the core is not halted and all clock enables stay high.
- R2: `lp_mode` codes are 000 Idle, 001 converter-quiet, 010 deep-off, 011 timer-keep. Codes 100 to 111 behave exactly as Idle.
- R3: Clock enables while asleep, in the order {cpu, flash, io, adc, async, osc}, are 001111 for Idle, 000111 for converter-quiet, 000000 for deep-off and 000010 for timer-keep.
- R4: Request lines are numbered 0 = external line 0, 1 = pin change, 2 = serial start condition, 3 = async timer, 4 = non-volatile memory ready, 5 = converter done, 6 and above = other I/O. Idle wakes on any line. Converter-quiet wakes on lines 0 to 5. Deep-off wakes on lines 0 to 2. Timer-keep wakes on lines 0 to 3.
- R5: In deep-off and timer-keep, line 0 wakes the core only while `ext0_level` = 1. With `ext0_level` = 0, a request on line 0 leaves the core asleep.
- R6: A request whose `irq_en` bit is 0 neither wakes the core nor cancels a sleep entry.
- R7: After a wake from deep-off or timer-keep, `osc_main_en` rises at once. The core stays halted until `osc_ready` is seen high.
- R8: The core stays halted for exactly 4 cycles after the oscillator is settled. In Idle and converter-quiet, those 4 cycles start at the wake cycle. `irq_service` is then high for exactly the first cycle with `core_halt` low.
- R9: If `bod_sleep_off` is 1 at entry, `bod_en` is low while asleep. It is high again from the first cycle after the wake. If `bod_sleep_off` is 0 at entry, `bod_en` stays high.
- R10: A reset while asleep returns the block to running, with all clock enables high, `bod_en` high, `core_halt` low and no `irq_service` pulse.
- R11: An enabled request present in the same cycle as the sleep strobe cancels the entry.
- R12: Out of reset, all clock enables and `bod_en` are high, and `core_halt` and `irq_service` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Permission bit for sleep entry |
| lp_mode | input | 3 | Low-power state code |
| sleep_exec | input | 1 | One-cycle sleep strobe from the core |
| bod_sleep_off | input | 1 | Turn the brown-out monitor off during this sleep |
| ext0_level | input | 1 | External line 0 is configured as level-triggered |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| osc_ready | input | 1 | Main oscillator start-up complete |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | Converter clock enable |
| clk_async_en | output | 1 | Asynchronous timer clock enable |
| osc_main_en | output | 1 | Main oscillator enable |
| core_halt | output | 1 | Core is held |
| bod_en | output | 1 | Brown-out monitor enable |
| irq_service | output | 1 | One-cycle pulse: core may take the waking interrupt |

## Verification
The assertions assume that `sleep_exec` is a single-cycle strobe issued only while the core runs. They also assume that `osc_ready` matters only while the controller waits for it, and that request lines are held until the wake is seen. The bench drives every input at the falling edge and raises the strobe for exactly one cycle. It holds `osc_ready` low except for a single cycle after a wait has been confirmed, and it clears request lines once a wake has been observed. It tests each line against each state code with one fixed enable pattern per case, so the wake and no-wake outcomes are all known in advance.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_ADCQ  = 3'd1,
    MODE_DOFF  = 3'd2,
    MODE_TKEEP = 3'd3
  } lp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_OSC_WAIT,
    ST_HALT
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic async_t;
    logic osc;
  } dom_en_t;

  localparam int unsigned SRC_EXT0   = 0;
  localparam int unsigned SRC_PINCHG = 1;
  localparam int unsigned SRC_START  = 2;
  localparam int unsigned SRC_ATMR   = 3;
  localparam int unsigned SRC_NVM    = 4;
  localparam int unsigned SRC_ADC    = 5;

  localparam dom_en_t DOM_ALL_ON = '{cpu: 1'b1, flash: 1'b1, io: 1'b1,
                                     adc: 1'b1, async_t: 1'b1, osc: 1'b1};

  // Reserved codes fall back to Idle.
  function automatic lp_mode_e mode_decode(input logic [2:0] code);
    case (code)
      3'd1:    return MODE_ADCQ;
      3'd2:    return MODE_DOFF;
      3'd3:    return MODE_TKEEP;
      default: return MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  lp_mode_e             mode,
  input  logic                 ext0_level,
  output logic [NUM_IRQ-1:0]   wake_mask
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    localparam int unsigned IDX = i;
    always_comb begin
      case (mode)
        MODE_ADCQ:  wake_mask[i] = (IDX <= SRC_ADC);
        MODE_DOFF:  wake_mask[i] = ((IDX == SRC_EXT0) && ext0_level) ||
                                   (IDX == SRC_PINCHG) || (IDX == SRC_START);
        MODE_TKEEP: wake_mask[i] = ((IDX == SRC_EXT0) && ext0_level) ||
                                   (IDX == SRC_PINCHG) || (IDX == SRC_START) ||
                                   (IDX == SRC_ATMR);
        default:    wake_mask[i] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pwr_domain_map.sv
module pwr_domain_map
  import pwr_sleep_pkg::*;
(
  input  lp_mode_e mode,
  output dom_en_t  sleep_map
);

  always_comb begin
    sleep_map = '0;
    case (mode)
      MODE_ADCQ: begin
        sleep_map.adc     = 1'b1;
        sleep_map.async_t = 1'b1;
        sleep_map.osc     = 1'b1;
      end
      MODE_DOFF: sleep_map = '0;
      MODE_TKEEP: sleep_map.async_t = 1'b1;
      default: begin
        sleep_map.io      = 1'b1;
        sleep_map.adc     = 1'b1;
        sleep_map.async_t = 1'b1;
        sleep_map.osc     = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pwr_halt_timer.sv
module pwr_halt_timer #(
  parameter int unsigned HALT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last
);

  localparam int unsigned CW = $clog2(HALT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(HALT_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CW'(1));

  // R8: the countdown never runs past its load value
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HALT_CYC));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 8,
  parameter int unsigned HALT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_en,
  input  logic [2:0]         lp_mode,
  input  logic               sleep_exec,
  input  logic               bod_sleep_off,
  input  logic               ext0_level,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               osc_ready,
  output logic               clk_cpu_en,
  output logic               clk_flash_en,
  output logic               clk_io_en,
  output logic               clk_adc_en,
  output logic               clk_async_en,
  output logic               osc_main_en,
  output logic               core_halt,
  output logic               bod_en,
  output logic               irq_service
);

  slp_state_e          state_q, state_d;
  lp_mode_e            mode_q;
  logic                bod_off_q;
  logic                svc_q;
  dom_en_t             sleep_map, dom;
  logic [NUM_IRQ-1:0]  wake_mask;
  logic                irq_pend, wake_hit, tmr_start, tmr_last;

  pwr_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .mode       (mode_q),
    .ext0_level (ext0_level),
    .wake_mask  (wake_mask)
  );

  pwr_domain_map u_map (
    .mode      (mode_q),
    .sleep_map (sleep_map)
  );

  pwr_halt_timer #(.HALT_CYC(HALT_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .last  (tmr_last)
  );

  assign irq_pend = |(irq_req & irq_en);
  assign wake_hit = |(irq_req & irq_en & wake_mask);

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    case (state_q)
      ST_RUN:
        if (sleep_exec && sleep_en && !irq_pend) state_d = ST_SLEEP;
      ST_SLEEP:
        if (wake_hit) begin
          if (sleep_map.osc) begin
            state_d   = ST_HALT;
            tmr_start = 1'b1;
          end else begin
            state_d = ST_OSC_WAIT;
          end
        end
      ST_OSC_WAIT:
        if (osc_ready) begin
          state_d   = ST_HALT;
          tmr_start = 1'b1;
        end
      default:
        if (tmr_last) state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      mode_q    <= MODE_IDLE;
      bod_off_q <= 1'b0;
      svc_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      svc_q   <= (state_q == ST_HALT) && (state_d == ST_RUN);
      if (state_q == ST_RUN && state_d == ST_SLEEP) begin
        mode_q    <= mode_decode(lp_mode);
        bod_off_q <= bod_sleep_off;
      end
    end
  end

  always_comb begin
    dom       = DOM_ALL_ON;
    core_halt = 1'b1;
    bod_en    = 1'b1;
    case (state_q)
      ST_RUN:   core_halt = 1'b0;
      ST_SLEEP: begin
        dom    = sleep_map;
        bod_en = !bod_off_q;
      end
      ST_OSC_WAIT: begin
        dom     = sleep_map;
        dom.osc = 1'b1;
      end
      default: ;
    endcase
  end

  assign clk_cpu_en   = dom.cpu;
  assign clk_flash_en = dom.flash;
  assign clk_io_en    = dom.io;
  assign clk_adc_en   = dom.adc;
  assign clk_async_en = dom.async_t;
  assign osc_main_en  = dom.osc;
  assign irq_service  = svc_q;

  // R1: strobe without permission keeps the core running
  a_r1_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_exec && !sleep_en) |=> !core_halt);

  // R11: pending enabled request cancels the entry
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_exec && |(irq_req & irq_en)) |=> !core_halt);

  // R5: an edge request on line 0 alone cannot end deep sleep
  a_r5_ext0_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && (mode_q == MODE_DOFF || mode_q == MODE_TKEEP) &&
     !ext0_level && (irq_req & irq_en) == NUM_IRQ'(1)) |=> core_halt && !osc_main_en);

  // R7: no progress past the oscillator wait without osc_ready
  a_r7_osc_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OSC_WAIT && !osc_ready) |=> (state_q == ST_OSC_WAIT));

  // R8: halt holds until the countdown ends; service follows a halt
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !tmr_last) |=> core_halt);
  a_r8_svc_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_service |-> ($past(core_halt) && !core_halt));

  // R9: monitor off only while fully asleep
  a_r9_bod_sleep_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bod_en |-> (core_halt && !clk_cpu_en));

  // R3: a gated CPU clock implies a halted core
  a_r3_cpu_gate_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_cpu_en |-> core_halt);

endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;

  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 1'b0, sleep_exec = 1'b0, bod_sleep_off = 1'b0;
  logic ext0_level = 1'b0, osc_ready = 1'b0;
  logic [2:0] lp_mode = 3'd0;
  logic [NI-1:0] irq_req = '0, irq_en = '1;
  logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_async_en;
  logic osc_main_en, core_halt, bod_en, irq_service;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_sleep_ctrl #(.NUM_IRQ(NI), .HALT_CYC(4)) uut (
    .clk, .rst_n, .sleep_en, .lp_mode, .sleep_exec, .bod_sleep_off,
    .ext0_level, .irq_req, .irq_en, .osc_ready,
    .clk_cpu_en, .clk_flash_en, .clk_io_en, .clk_adc_en, .clk_async_en,
    .osc_main_en, .core_halt, .bod_en, .irq_service
  );

  function automatic logic [5:0] doms();
    return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_async_en, osc_main_en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {mode[3], bod_off, src[3], ext0_level, exp_doms[6], exp_wake}
  localparam logic [14:0] VECS [12] = '{
    {3'd0, 1'b0, 3'd6, 1'b0, 6'b001111, 1'b1},
    {3'd0, 1'b1, 3'd0, 1'b0, 6'b001111, 1'b1},
    {3'd1, 1'b0, 3'd5, 1'b0, 6'b000111, 1'b1},
    {3'd1, 1'b0, 3'd6, 1'b0, 6'b000111, 1'b0},
    {3'd2, 1'b1, 3'd0, 1'b1, 6'b000000, 1'b1},
    {3'd2, 1'b0, 3'd0, 1'b0, 6'b000000, 1'b0},
    {3'd2, 1'b0, 3'd3, 1'b0, 6'b000000, 1'b0},
    {3'd3, 1'b0, 3'd3, 1'b0, 6'b000010, 1'b1},
    {3'd3, 1'b1, 3'd2, 1'b0, 6'b000010, 1'b1},
    {3'd5, 1'b0, 3'd6, 1'b0, 6'b001111, 1'b1},
    {3'd3, 1'b0, 3'd5, 1'b0, 6'b000010, 1'b0},
    {3'd1, 1'b0, 3'd4, 1'b0, 6'b000111, 1'b1}
  };

  task automatic enter_sleep(input logic [2:0] m, input logic bod);
    @(negedge clk);
    sleep_en = 1'b1; lp_mode = m; bod_sleep_off = bod; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
  endtask

  // Called at the first sample after the waking edge.
  task automatic finish_wake(input bit osc_stopped);
    irq_req = '0;
    chk("R9 bod back on wake", int'(bod_en), 1);
    if (osc_stopped) begin
      chk("R7 osc on at wake", int'(osc_main_en), 1);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R7 held for osc", int'(core_halt), 1);
      end
      osc_ready = 1'b1;
      @(negedge clk);
      osc_ready = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin
      chk("R8 halt cycle", int'({core_halt, irq_service}), 2);
      @(negedge clk);
    end
    chk("R8 service pulse", int'({core_halt, irq_service}), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(irq_service), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset doms", int'(doms()), 6'h3f);
    chk("R12 reset halt/svc/bod", int'({core_halt, irq_service, bod_en}), 1);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[v]) begin
      logic [2:0] m   = VECS[v][14:12];
      logic       bod = VECS[v][11];
      logic [2:0] src = VECS[v][10:8];
      logic [5:0] ed  = VECS[v][6:1];
      logic       wk  = VECS[v][0];
      ext0_level = VECS[v][7];
      enter_sleep(m, bod);
      chk("R2 R3 sleep doms", int'(doms()), int'(ed));
      chk("R9 bod in sleep", int'(bod_en), int'(!bod));
      irq_req[src] = 1'b1;
      @(negedge clk);
      if (wk) begin
        chk("R4 woke", int'(core_halt && (clk_cpu_en || osc_main_en)), 1);
        finish_wake(ed[0] == 1'b0);
      end else begin
        chk("R4 R5 no wake", int'(doms()), int'(ed));
        @(negedge clk);
        chk("R4 R5 still asleep", int'(core_halt), 1);
        irq_req = '0;
        irq_req[1] = 1'b1;
        @(negedge clk);
        finish_wake(ed[0] == 1'b0);
      end
    end

    // R1: strobe with permission clear
    @(negedge clk);
    sleep_en = 1'b0; lp_mode = 3'd2; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    chk("R1 no entry", int'({core_halt, doms()}), 7'h3f);

    // R11: enabled request with the strobe cancels entry
    @(negedge clk);
    sleep_en = 1'b1; lp_mode = 3'd2; sleep_exec = 1'b1; irq_req[6] = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0; irq_req = '0;
    chk("R11 cancel", int'({core_halt, doms()}), 7'h3f);

    // R6: disabled request neither cancels nor wakes
    @(negedge clk);
    irq_en = 8'hbf; irq_req[6] = 1'b1; lp_mode = 3'd0; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
    chk("R6 entry despite masked req", int'(core_halt), 1);
    @(negedge clk);
    chk("R6 masked req no wake", int'(doms()), 6'b001111);
    irq_en = '1;
    @(negedge clk);
    finish_wake(1'b0);

    // R10: reset while asleep in deep-off with monitor off
    enter_sleep(3'd2, 1'b1);
    chk("R10 asleep before reset", int'({core_halt, bod_en}), 2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 after reset", int'({core_halt, irq_service, bod_en, doms()}), 9'h07f);
    @(negedge clk);
    chk("R10 no service pulse", int'({core_halt, irq_service}), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule